// File: doc/BRIEF.md
# GPIO Pin Interrupt Detector

This block watches the synchronized input levels of a small GPIO port and raises one interrupt request when any enabled pin sees its configured trigger. Each pin is set on its own: it can sense an edge or a level, an edge can be a single edge or either edge, and a polarity bit picks the rising edge or high level over the falling edge or low level. A per-pin mask keeps a pin's trigger away from the status and the interrupt line.

Edge triggers are latched per pin and stay latched until software writes a one to that pin's bit in a write-one-to-clear register. Level triggers are not latched; they follow the pin. Software reads a masked status word, services the pins it shows, and acknowledges them through the clear register. The request line is the OR of the masked status bits. The register port is a simple single-cycle bus with a combinational read.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset the sense, any-edge and polarity registers read 0, the mask register reads all ones, the status reads 0 and `irq_o` is low.
- R2: Word offsets are sense 0, any-edge 1, polarity 2, mask 3, status 4 and clear 5. Bit i of every register belongs to pin i. The first four read back what was written. A write to status has no effect, and clear reads as 0.
- R3: With sense bit 0 (edge), any-edge bit 0 and polarity bit 1, a 0-to-1 change of the pin sets its status bit at the first rising clock edge that samples the new level. A 1-to-0 change sets nothing.
- R4: With sense 0, any-edge 0 and polarity 0, a falling pin sets its status bit, and a rising pin sets nothing.
- R5: With any-edge bit 1 in edge mode, both the rising and the falling change set the status bit, whatever the polarity bit holds.
- R6: Edge status stays set after the pin returns, until a 1 is written to that bit of the clear register. A 0 in the clear word leaves the bit set.
- R7: If a clear and a new qualifying edge of the same pin land in the same clock cycle, the status bit stays set.
- R8: With sense bit 1 (level), the status bit is 1 exactly while the pin equals its polarity bit. It is not latched, and the any-edge bit has no effect.
- R9: A mask bit of 1 forces that pin's status bit and its share of `irq_o` to 0. An edge that arrives while the pin is masked is still latched, and it shows up once the mask bit is cleared.
- R10: `irq_o` is the OR of all status bits.
- R11: A pin held at a constant level in edge mode never sets its status bit, because an edge is a difference from the level sampled one cycle earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pins_i | input | NPINS | Synchronized pin levels |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | ADDR_W | Register word offset |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Combinational read data |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with its default values: eight pins, a three-bit word address and an eight-bit data bus. With these values every register is one bus word, so each pin's bit can be driven and read on its own. At this width the bench can work several pins at once in distinct modes: an edge pin and a level pin sharing the request line, or a masked pin next to an unmasked one. The clear/edge collision and the masked-then-released edge are reachable on any pin with a short directed sequence.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

   // word offsets of the register file
   localparam int unsigned OFS_SENSE = 0;
   localparam int unsigned OFS_BOTH  = 1;
   localparam int unsigned OFS_POL   = 2;
   localparam int unsigned OFS_MASK  = 3;
   localparam int unsigned OFS_STAT  = 4;
   localparam int unsigned OFS_CLR   = 5;

   localparam int unsigned MIN_ADDR_W = 3;

endpackage

// File: rtl/gpio_irq_slice.sv
module gpio_irq_slice (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic pin_i,
   input  logic level_mode_i,
   input  logic any_edge_i,
   input  logic active_hi_i,
   input  logic clr_i,
   output logic raw_o
);

   logic prev_q;
   logic lat_q;
   logic rise;
   logic fall;
   logic hit;
   logic lvl_hit;

   assign rise    = pin_i & ~prev_q;
   assign fall    = ~pin_i & prev_q;
   assign hit     = any_edge_i ? (rise | fall) : (active_hi_i ? rise : fall);
   assign lvl_hit = active_hi_i ? pin_i : ~pin_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         prev_q <= 1'b0;
         lat_q  <= 1'b0;
      end else begin
         prev_q <= pin_i;
         if (level_mode_i) lat_q <= 1'b0;
         else              lat_q <= hit | (lat_q & ~clr_i);
      end
   end

   assign raw_o = level_mode_i ? lvl_hit : lat_q;

   // R6: a latched edge survives cycles without a clear
   p_edge_hold_r6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!level_mode_i && lat_q && !clr_i) |=> lat_q);

   // R6: a clear without a fresh edge drops the latch
   p_edge_clear_r6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!level_mode_i && clr_i && !hit) |=> !lat_q);

   // R7: a fresh edge wins over a simultaneous clear
   p_clr_collide_r7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!level_mode_i && clr_i && hit) |=> lat_q);

   // R8: level mode keeps nothing latched
   p_level_nolatch_r8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      level_mode_i |=> !lat_q);

endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
   import gpio_irq_pkg::*;
#(
   parameter int unsigned NPINS  = 8,
   parameter int unsigned ADDR_W = 3,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [NPINS-1:0]  status_i,
   output logic [NPINS-1:0]  sense_o,
   output logic [NPINS-1:0]  both_o,
   output logic [NPINS-1:0]  pol_o,
   output logic [NPINS-1:0]  mask_o,
   output logic [NPINS-1:0]  clr_o,
   output logic [DATA_W-1:0] rdata_o
);

   localparam logic [ADDR_W-1:0] A_SENSE = ADDR_W'(OFS_SENSE);
   localparam logic [ADDR_W-1:0] A_BOTH  = ADDR_W'(OFS_BOTH);
   localparam logic [ADDR_W-1:0] A_POL   = ADDR_W'(OFS_POL);
   localparam logic [ADDR_W-1:0] A_MASK  = ADDR_W'(OFS_MASK);
   localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(OFS_STAT);
   localparam logic [ADDR_W-1:0] A_CLR   = ADDR_W'(OFS_CLR);

   logic [NPINS-1:0] wbits;
   assign wbits = wdata_i[NPINS-1:0];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sense_o <= '0;
         both_o  <= '0;
         pol_o   <= '0;
         mask_o  <= '1;
      end else if (wr_i) begin
         if (addr_i == A_SENSE) sense_o <= wbits;
         if (addr_i == A_BOTH)  both_o  <= wbits;
         if (addr_i == A_POL)   pol_o   <= wbits;
         if (addr_i == A_MASK)  mask_o  <= wbits;
      end
   end

   assign clr_o = (wr_i && addr_i == A_CLR) ? wbits : '0;

   always_comb begin
      rdata_o = '0;
      case (addr_i)
         A_SENSE: rdata_o = DATA_W'(sense_o);
         A_BOTH:  rdata_o = DATA_W'(both_o);
         A_POL:   rdata_o = DATA_W'(pol_o);
         A_MASK:  rdata_o = DATA_W'(mask_o);
         A_STAT:  rdata_o = DATA_W'(status_i);
         default: rdata_o = '0;
      endcase
   end

   // R2: a write to the status offset leaves the configuration untouched
   p_stat_ro_r2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && addr_i == A_STAT) |=> ($stable(sense_o) && $stable(both_o)
                                      && $stable(pol_o) && $stable(mask_o)));

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
   import gpio_irq_pkg::*;
#(
   parameter int unsigned NPINS  = 8,
   parameter int unsigned ADDR_W = 3,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [NPINS-1:0]  pins_i,
   input  logic              bus_wr_i,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic [DATA_W-1:0] bus_wdata_i,
   output logic [DATA_W-1:0] bus_rdata_o,
   output logic              irq_o
);

   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);

   if (NPINS < 1 || NPINS > 32) begin : g_bad_npins
      $error("gpio_irq_ctrl: NPINS must lie in 1..32");
   end
   if (DATA_W < NPINS) begin : g_bad_dataw
      $error("gpio_irq_ctrl: DATA_W must cover NPINS");
   end
   if (ADDR_W < MIN_ADDR_W) begin : g_bad_addrw
      $error("gpio_irq_ctrl: ADDR_W too small for the register map");
   end

   logic [NPINS-1:0] sense;
   logic [NPINS-1:0] both;
   logic [NPINS-1:0] pol;
   logic [NPINS-1:0] mask;
   logic [NPINS-1:0] clr;
   logic [NPINS-1:0] raw;
   logic [NPINS-1:0] status;

   gpio_irq_regs #(
      .NPINS (NPINS),
      .ADDR_W(ADDR_W),
      .DATA_W(DATA_W)
   ) u_regs (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (bus_wr_i),
      .addr_i  (bus_addr_i),
      .wdata_i (bus_wdata_i),
      .status_i(status),
      .sense_o (sense),
      .both_o  (both),
      .pol_o   (pol),
      .mask_o  (mask),
      .clr_o   (clr),
      .rdata_o (bus_rdata_o)
   );

   for (genvar i = 0; i < NPINS; i++) begin : g_pin
      gpio_irq_slice u_slice (
         .clk_i       (clk_i),
         .rst_ni      (rst_ni),
         .pin_i       (pins_i[i]),
         .level_mode_i(sense[i]),
         .any_edge_i  (both[i]),
         .active_hi_i (pol[i]),
         .clr_i       (clr[i]),
         .raw_o       (raw[i])
      );
   end

   assign status = raw & ~mask;
   assign irq_o  = |status;

   // R10: the request line matches the status word seen on the bus
   p_irq_or_r10 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!bus_wr_i && bus_addr_i == A_STAT) |-> (irq_o == |bus_rdata_o[NPINS-1:0]));

   // R9: masked pins never show in the status read
   p_mask_blocks_r9 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bus_addr_i == A_STAT) |-> ((bus_rdata_o[NPINS-1:0] & mask) == '0));

endmodule

// File: tb/gpio_irq_ctrl_bench.sv
module gpio_irq_ctrl_bench;

   localparam int A_SENSE = 0;
   localparam int A_BOTH  = 1;
   localparam int A_POL   = 2;
   localparam int A_MASK  = 3;
   localparam int A_STAT  = 4;
   localparam int A_CLR   = 5;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] pins = 8'h00;
   logic       bus_wr = 1'b0;
   logic [2:0] bus_addr = 3'd0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic       irq;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #5 clk = ~clk;

   gpio_irq_ctrl #(.NPINS(8), .ADDR_W(3), .DATA_W(8)) u_gpio_irq_ctrl (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .pins_i     (pins),
      .bus_wr_i   (bus_wr),
      .bus_addr_i (bus_addr),
      .bus_wdata_i(bus_wdata),
      .bus_rdata_o(bus_rdata),
      .irq_o      (irq)
   );

   task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%02h expected 0x%02h", req, got, exp);
      end
   endtask

   task automatic wr(input int a, input logic [7:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a[2:0]; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input int a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a[2:0];
      #1 d = bus_rdata;
   endtask

   task automatic setp(input logic [7:0] v);
      @(negedge clk);
      pins = v;
   endtask

   task automatic cleanup();
      wr(A_MASK, 8'hFF);
      setp(8'h00);
      wr(A_SENSE, 8'h00);
      wr(A_BOTH, 8'h00);
      wr(A_POL, 8'h00);
      wr(A_CLR, 8'hFF);
   endtask

   task automatic t_reset();
      logic [7:0] d;
      rd(A_SENSE, d); chk("R1 sense", d, 8'h00);
      rd(A_BOTH, d);  chk("R1 both", d, 8'h00);
      rd(A_POL, d);   chk("R1 pol", d, 8'h00);
      rd(A_MASK, d);  chk("R1 mask", d, 8'hFF);
      rd(A_STAT, d);  chk("R1 status", d, 8'h00);
      chk("R1 irq", {7'd0, irq}, 8'h00);
   endtask

   task automatic t_regs();
      logic [7:0] d;
      wr(A_SENSE, 8'hA5); rd(A_SENSE, d); chk("R2 sense readback", d, 8'hA5);
      wr(A_BOTH, 8'h3C);  rd(A_BOTH, d);  chk("R2 both readback", d, 8'h3C);
      wr(A_POL, 8'h96);   rd(A_POL, d);   chk("R2 pol readback", d, 8'h96);
      wr(A_MASK, 8'h5A);  rd(A_MASK, d);  chk("R2 mask readback", d, 8'h5A);
      wr(A_STAT, 8'hFF);
      rd(A_SENSE, d); chk("R2 status write ignored sense", d, 8'hA5);
      rd(A_MASK, d);  chk("R2 status write ignored mask", d, 8'h5A);
      rd(A_CLR, d);   chk("R2 clear reads zero", d, 8'h00);
      cleanup();
   endtask

   task automatic t_rise();
      logic [7:0] d;
      wr(A_POL, 8'h01); wr(A_MASK, 8'h00);
      setp(8'h01); rd(A_STAT, d); chk("R3 rising latched", d, 8'h01);
      chk("R3 irq on rise", {7'd0, irq}, 8'h01);
      wr(A_CLR, 8'h01); rd(A_STAT, d); chk("R3 cleared", d, 8'h00);
      setp(8'h00); rd(A_STAT, d); chk("R3 falling ignored", d, 8'h00);
      cleanup();
   endtask

   task automatic t_fall();
      logic [7:0] d;
      wr(A_MASK, 8'h00);
      setp(8'h02); rd(A_STAT, d); chk("R4 rising ignored", d, 8'h00);
      setp(8'h00); rd(A_STAT, d); chk("R4 falling latched", d, 8'h02);
      cleanup();
   endtask

   task automatic t_both();
      logic [7:0] d;
      wr(A_BOTH, 8'h04); wr(A_POL, 8'h00); wr(A_MASK, 8'h00);
      setp(8'h04); rd(A_STAT, d); chk("R5 rise with any-edge", d, 8'h04);
      wr(A_CLR, 8'h04);
      setp(8'h00); rd(A_STAT, d); chk("R5 fall with any-edge", d, 8'h04);
      wr(A_CLR, 8'h04); wr(A_POL, 8'h04);
      setp(8'h04); rd(A_STAT, d); chk("R5 polarity ignored", d, 8'h04);
      cleanup();
   endtask

   task automatic t_hold();
      logic [7:0] d;
      wr(A_POL, 8'h08); wr(A_MASK, 8'h00);
      setp(8'h08); setp(8'h00);
      repeat (4) @(negedge clk);
      rd(A_STAT, d); chk("R6 held after pin returns", d, 8'h08);
      wr(A_CLR, 8'hF7); rd(A_STAT, d); chk("R6 zero bit no effect", d, 8'h08);
      wr(A_CLR, 8'h08); rd(A_STAT, d); chk("R6 one bit clears", d, 8'h00);
      cleanup();
   endtask

   task automatic t_collide();
      logic [7:0] d;
      wr(A_POL, 8'h01); wr(A_MASK, 8'h00);
      setp(8'h01); setp(8'h00);
      @(negedge clk);
      pins = 8'h01; bus_wr = 1'b1; bus_addr = 3'(A_CLR); bus_wdata = 8'h01;
      @(negedge clk);
      bus_wr = 1'b0;
      rd(A_STAT, d); chk("R7 edge beats clear", d, 8'h01);
      wr(A_CLR, 8'h01); rd(A_STAT, d); chk("R7 later clear works", d, 8'h00);
      cleanup();
   endtask

   task automatic t_level();
      logic [7:0] d;
      wr(A_SENSE, 8'h30); wr(A_POL, 8'h10); wr(A_BOTH, 8'h10); wr(A_MASK, 8'h00);
      // pin4 active high, pin5 active low; pins low: only pin5 asserts
      rd(A_STAT, d); chk("R8 low levels", d, 8'h20);
      setp(8'h30); rd(A_STAT, d); chk("R8 high levels", d, 8'h10);
      setp(8'h00); rd(A_STAT, d); chk("R8 not latched", d, 8'h20);
      cleanup();
   endtask

   task automatic t_mask();
      logic [7:0] d;
      wr(A_POL, 8'h41); wr(A_MASK, 8'h40);
      setp(8'h40); rd(A_STAT, d); chk("R9 masked status", d, 8'h00);
      chk("R9 masked irq", {7'd0, irq}, 8'h00);
      setp(8'h00);
      wr(A_MASK, 8'h00); rd(A_STAT, d); chk("R9 revealed on unmask", d, 8'h40);
      chk("R9 irq after unmask", {7'd0, irq}, 8'h01);
      cleanup();
   endtask

   task automatic t_irq();
      logic [7:0] d;
      wr(A_POL, 8'h81); wr(A_MASK, 8'h00);
      setp(8'h81); rd(A_STAT, d); chk("R10 two pins", d, 8'h81);
      wr(A_CLR, 8'h80); rd(A_STAT, d);
      chk("R10 irq one left", {7'd0, irq}, 8'h01);
      wr(A_CLR, 8'h01); rd(A_STAT, d);
      chk("R10 irq none left", {7'd0, irq}, 8'h00);
      cleanup();
   endtask

   task automatic t_steady();
      logic [7:0] d;
      wr(A_BOTH, 8'hFF); wr(A_MASK, 8'h00);
      setp(8'hFF);
      wr(A_CLR, 8'hFF);
      repeat (5) @(negedge clk);
      rd(A_STAT, d); chk("R11 constant high no edge", d, 8'h00);
      chk("R11 irq quiet", {7'd0, irq}, 8'h00);
      cleanup();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_regs();
      t_rise();
      t_fall();
      t_both();
      t_hold();
      t_collide();
      t_level();
      t_mask();
      t_irq();
      t_steady();
      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      #500000;
      if (!done) begin
         done = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog (all requirements): actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

endmodule